// File: doc/BRIEF.md
# Configuration Container Section Extractor

This block takes a configuration container as a stream of bytes and pulls one section out of it. The container opens with a fixed 13-byte signature. A chain of sections follows. Each section has a one-byte type letter, a big-endian length field and then that many bytes of content. The section type to extract is set on a static input, and is normally the letter that carries the raw configuration data. The payload of that section goes out on a valid/ready byte stream, and its final byte is marked. Every other section is skipped by its length and produces no output.

When parsing ends, the block raises a sticky done flag with a two-bit result. The result is one of four values: found, not found, signature mismatch, or malformed container. After done, the block accepts and discards every further input byte until reset. It does not interpret the content of any section.

Top module: `cfgimg_section_extract`

## Requirements
- R1: While and after reset, `done` is 0, `in_ready` is 1 and `out_valid` is 0.
- R2: The first 13 input bytes must equal 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01. The first byte that differs ends parsing with `done`=1 and `status`=2 (signature mismatch). An `in_last` inside the signature also ends parsing with `status`=2.
- R3: After the signature, each section is parsed as one type byte, then a big-endian length, then content. The length is 4 bytes when the type is 0x65 ('e') and 2 bytes for every other type. A section whose type differs from `want_type` produces no output.
- R4: The content of the section whose type equals `want_type` appears on `out_data` byte for byte, in order. `out_last` is set on its final byte only. The cycle after that byte is accepted, `done`=1 and `status`=1 (found).
- R5: A type byte below 0x61 or above 0x65 ends parsing with `status`=3 (malformed).
- R6: A length value above 255 in a section of type other than 0x65 ends parsing with `status`=3. A length of exactly 255 in such a section is accepted. A length above 255 in a 0x65 section is accepted.
- R7: If `in_last` arrives on the final byte of a skipped section, the result is `status`=0 (not found). The final byte may be a content byte, or a length byte when the length is zero. The same result applies when `in_last` arrives on the final signature byte.
- R8: `in_last` on a type byte, on a non-final length byte, or on any content byte before the last one ends parsing with `status`=3.
- R9: While the selected content is being forwarded and `out_ready` is 0, `in_ready` is 0 and no input byte is consumed.
- R10: Once `done` is 1, `in_ready` stays 1, `out_valid` stays 0, and no further input changes `done` or `status` until reset.
- R11: A selected section of length zero gives `done`=1 and `status`=1 with no output byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| want_type | input | 8 | Section type letter to extract (static) |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte present |
| in_last | input | 1 | Input byte is the final byte of the container |
| in_ready | output | 1 | Input byte accepted this cycle |
| out_data | output | 8 | Extracted payload byte |
| out_valid | output | 1 | Payload byte present |
| out_last | output | 1 | Final payload byte of the selected section |
| out_ready | input | 1 | Downstream accepts the payload byte |
| done | output | 1 | Parsing finished (sticky until reset) |
| status | output | 2 | Result once done: 0 not found, 1 found, 2 signature mismatch, 3 malformed |

## Verification
The bench builds the block with its default parameters: a 2-byte short length, a 4-byte long length and a short-length limit of 255. With these values the limit can be probed from both sides, at a 255-byte section that is accepted and a 256-byte one that is rejected. A 300-byte long-length section is skipped without error. The 4-byte length path is exercised both as the extracted section and as a skipped one. Backpressure uses a repeating stall on the output, so that a long payload passes through many stalled cycles.

// File: rtl/cfgimg_pkg.sv
package cfgimg_pkg;

    localparam int          MAGIC_LEN = 13;
    localparam logic [7:0]  TYPE_MIN  = 8'h61;
    localparam logic [7:0]  TYPE_MAX  = 8'h65;
    localparam logic [7:0]  TYPE_WIDE = 8'h65;

    typedef enum logic [2:0] {
        PS_MAGIC,
        PS_TYPE,
        PS_LEN,
        PS_BODY,
        PS_DONE
    } pstate_t;

    typedef enum logic [1:0] {
        RES_ABSENT    = 2'd0,
        RES_FOUND     = 2'd1,
        RES_BADMAGIC  = 2'd2,
        RES_MALFORMED = 2'd3
    } result_t;

    typedef struct packed {
        logic known;
        logic wide_len;
        logic wanted;
    } kind_t;

    function automatic logic [7:0] magic_byte(input logic [3:0] idx);
        logic [7:0] b;
        case (idx)
            4'd0, 4'd10, 4'd11: b = 8'h00;
            4'd1:               b = 8'h09;
            4'd2, 4'd4, 4'd6, 4'd8: b = 8'h0F;
            4'd3, 4'd5, 4'd7, 4'd9: b = 8'hF0;
            4'd12:              b = 8'h01;
            default:            b = 8'h00;
        endcase
        return b;
    endfunction

    function automatic kind_t classify(input logic [7:0] t, input logic [7:0] want);
        kind_t k;
        k.known    = (t >= TYPE_MIN) && (t <= TYPE_MAX);
        k.wide_len = (t == TYPE_WIDE);
        k.wanted   = (t == want);
        return k;
    endfunction

endpackage

// File: rtl/cfgimg_magic_check.sv
module cfgimg_magic_check #(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       byte_in,
    output logic             match,
    output logic             final_byte
);
    import cfgimg_pkg::*;

    always_comb begin
        match      = (byte_in == magic_byte(4'(idx)));
        final_byte = (idx == IDX_W'(MAGIC_LEN - 1));
    end
endmodule

// File: rtl/cfgimg_hdr_decode.sv
module cfgimg_hdr_decode (
    input  logic [7:0]          type_in,
    input  logic [7:0]          want,
    output cfgimg_pkg::kind_t   kind
);
    import cfgimg_pkg::*;

    always_comb kind = classify(type_in, want);
endmodule

// File: rtl/cfgimg_len_track.sv
module cfgimg_len_track #(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             shift,
    input  logic             load,
    input  logic             dec,
    input  logic [7:0]       byte_in,
    output logic [LEN_W-1:0] assembled,
    output logic             at_end
);
    logic [LEN_W-9:0] acc;
    logic [LEN_W-1:0] remain;

    assign assembled = {acc, byte_in};
    assign at_end    = (remain == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            remain <= '0;
        end else begin
            if (clr)
                acc <= '0;
            else if (shift)
                acc <= assembled[LEN_W-9:0];
            if (load)
                remain <= assembled;
            else if (dec)
                remain <= remain - LEN_W'(1);
        end
    end
endmodule

// File: rtl/cfgimg_section_extract.sv
module cfgimg_section_extract #(
    parameter int SHORT_BYTES = 2,
    parameter int WIDE_BYTES  = 4,
    parameter int SHORT_MAX   = 255
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] want_type,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_last,
    output logic       in_ready,
    output logic [7:0] out_data,
    output logic       out_valid,
    output logic       out_last,
    input  logic       out_ready,
    output logic       done,
    output logic [1:0] status
);
    import cfgimg_pkg::*;

    localparam int LEN_W = 8 * WIDE_BYTES;
    localparam int IDX_W = $clog2(MAGIC_LEN);
    localparam int CNT_W = $clog2(WIDE_BYTES + 1);

    pstate_t          st, st_n;
    result_t          res, res_n;
    logic [IDX_W-1:0] idx, idx_n;
    logic [CNT_W-1:0] left, left_n;
    logic             cur_sel, sel_n, cur_wide, wide_n;
    logic             acc_clr, acc_shift, rem_load, rem_dec;
    logic             magic_ok, magic_end, at_end, consume, passing;
    logic [LEN_W-1:0] assembled;
    kind_t            kind;

    cfgimg_magic_check #(.IDX_W(IDX_W)) magic_i (
        .idx(idx), .byte_in(in_data), .match(magic_ok), .final_byte(magic_end)
    );

    cfgimg_hdr_decode hdr_i (
        .type_in(in_data), .want(want_type), .kind(kind)
    );

    cfgimg_len_track #(.LEN_W(LEN_W)) len_i (
        .clk(clk), .rst(rst), .clr(acc_clr), .shift(acc_shift), .load(rem_load),
        .dec(rem_dec), .byte_in(in_data), .assembled(assembled), .at_end(at_end)
    );

    assign passing   = (st == PS_BODY) && cur_sel;
    assign in_ready  = passing ? out_ready : 1'b1;
    assign out_valid = passing && in_valid;
    assign out_data  = in_data;
    assign out_last  = out_valid && at_end;
    assign consume   = in_valid && in_ready;
    assign done      = (st == PS_DONE);
    assign status    = res;

    always_comb begin
        st_n = st; res_n = res; idx_n = idx; left_n = left;
        sel_n = cur_sel; wide_n = cur_wide;
        acc_clr = 1'b0; acc_shift = 1'b0; rem_load = 1'b0; rem_dec = 1'b0;
        if (consume) begin
            unique case (st)
                PS_MAGIC: begin
                    if (!magic_ok || (in_last && !magic_end)) begin
                        st_n = PS_DONE; res_n = RES_BADMAGIC;
                    end else if (magic_end) begin
                        st_n = in_last ? PS_DONE : PS_TYPE;
                    end else begin
                        idx_n = idx + IDX_W'(1);
                    end
                end
                PS_TYPE: begin
                    if (!kind.known || in_last) begin
                        st_n = PS_DONE; res_n = RES_MALFORMED;
                    end else begin
                        st_n    = PS_LEN;
                        sel_n   = kind.wanted;
                        wide_n  = kind.wide_len;
                        left_n  = kind.wide_len ? CNT_W'(WIDE_BYTES) : CNT_W'(SHORT_BYTES);
                        acc_clr = 1'b1;
                    end
                end
                PS_LEN: begin
                    if (left == CNT_W'(1)) begin
                        if (!cur_wide && (assembled > LEN_W'(SHORT_MAX))) begin
                            st_n = PS_DONE; res_n = RES_MALFORMED;
                        end else if (assembled == '0) begin
                            if (cur_sel) begin
                                st_n = PS_DONE; res_n = RES_FOUND;
                            end else begin
                                st_n = in_last ? PS_DONE : PS_TYPE;
                            end
                        end else if (in_last) begin
                            st_n = PS_DONE; res_n = RES_MALFORMED;
                        end else begin
                            st_n = PS_BODY; rem_load = 1'b1;
                        end
                    end else if (in_last) begin
                        st_n = PS_DONE; res_n = RES_MALFORMED;
                    end else begin
                        acc_shift = 1'b1;
                        left_n    = left - CNT_W'(1);
                    end
                end
                PS_BODY: begin
                    rem_dec = 1'b1;
                    if (at_end) begin
                        if (cur_sel) begin
                            st_n = PS_DONE; res_n = RES_FOUND;
                        end else begin
                            st_n = in_last ? PS_DONE : PS_TYPE;
                        end
                    end else if (in_last) begin
                        st_n = PS_DONE; res_n = RES_MALFORMED;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= PS_MAGIC;
            res      <= RES_ABSENT;
            idx      <= '0;
            left     <= '0;
            cur_sel  <= 1'b0;
            cur_wide <= 1'b0;
        end else begin
            st       <= st_n;
            res      <= res_n;
            idx      <= idx_n;
            left     <= left_n;
            cur_sel  <= sel_n;
            cur_wide <= wide_n;
        end
    end
endmodule

// File: rtl/cfgimg_section_extract_chk.sv
module cfgimg_section_extract_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic       out_last,
    input logic       done,
    input logic [1:0] status
);
    // R1
    a_r1_reset_clears: assert property (@(posedge clk) rst |=> !done && in_ready && !out_valid);
    // R10
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst) done |=> done);
    a_r10_status_hold: assert property (@(posedge clk) disable iff (rst) done |=> $stable(status));
    a_r10_drain_quiet: assert property (@(posedge clk) disable iff (rst) done |-> in_ready && !out_valid);
    // R9
    a_r9_backpressure: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);
    // R4
    a_r4_found_after_last: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> done && status == 2'd1);
endmodule

bind cfgimg_section_extract cfgimg_section_extract_chk chk_i (
    .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_last(out_last), .done(done), .status(status)
);

// File: tb/cfgimg_section_extract_tb_top.sv
module cfgimg_section_extract_tb_top;
    localparam logic [1:0] ST_ABSENT = 2'd0, ST_FOUND = 2'd1, ST_BADMAGIC = 2'd2, ST_MALFORMED = 2'd3;
    localparam logic [7:0] MAGIC [13] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F,
                                         8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};

    logic       clk = 1'b0, rst = 1'b1;
    logic [7:0] want_type = 8'h65, in_data = '0, out_data;
    logic       in_valid = 1'b0, in_last = 1'b0, in_ready, out_valid, out_last, out_ready = 1'b1, done;
    logic [1:0] status;

    int checks = 0, failures = 0;
    logic [7:0] stim [0:1023];
    logic [7:0] expb [0:1023];
    logic [7:0] got  [0:1023];
    int stim_n, exp_n, got_n, last_cnt, last_at, bp_bad, drop_bad;

    cfgimg_section_extract dut_i (
        .clk(clk), .rst(rst), .want_type(want_type), .in_data(in_data), .in_valid(in_valid),
        .in_last(in_last), .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
        .out_last(out_last), .out_ready(out_ready), .done(done), .status(status)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic do_reset(input logic [7:0] want);
        want_type = want; rst = 1'b1; in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        stim_n = 0; exp_n = 0;
    endtask

    task automatic put(input logic [7:0] b);
        stim[stim_n] = b; stim_n++;
    endtask

    task automatic put_magic(input int upto, input int bad_at);
        for (int k = 0; k < upto; k++) put(k == bad_at ? (MAGIC[k] ^ 8'h40) : MAGIC[k]);
    endtask

    task automatic put_hdr(input logic [7:0] t, input int len);
        put(t);
        if (t == 8'h65) begin put(8'(len >> 24)); put(8'(len >> 16)); end
        put(8'(len >> 8)); put(8'(len));
    endtask

    task automatic put_body(input int len, input int seed, input bit keep);
        for (int k = 0; k < len; k++) begin
            logic [7:0] b;
            b = 8'((seed + k * 13) ^ (k >> 3));
            put(b);
            if (keep) begin expb[exp_n] = b; exp_n++; end
        end
    endtask

    task automatic run_stream(input bit stall);
        int idx = 0, cyc = 0;
        got_n = 0; last_cnt = 0; last_at = -1; bp_bad = 0; drop_bad = 0;
        while (idx < stim_n && cyc < 20000) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = stim[idx]; in_last = (idx == stim_n - 1);
            out_ready = stall ? (cyc % 3 != 1) : 1'b1;
            #1;
            if (out_valid && !out_ready && in_ready) bp_bad++;
            if (done && (!in_ready || out_valid)) drop_bad++;
            if (out_valid && out_ready) begin
                got[got_n] = out_data;
                if (out_last) begin last_cnt++; last_at = got_n; end
                got_n++;
            end
            if (in_ready) idx++;
            cyc++;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b1;
        repeat (2) @(negedge clk);
        #1;
    endtask

    task automatic check_end(input string req, input logic [1:0] exp_st);
        check(done === 1'b1, req, done, 1);
        check(status === exp_st, req, status, exp_st);
        check(drop_bad == 0, "R10 drain after done", drop_bad, 0);
    endtask

    task automatic check_payload(input string req);
        int bad = 0;
        check(got_n == exp_n, req, got_n, exp_n);
        for (int k = 0; k < got_n && k < exp_n; k++) if (got[k] !== expb[k]) bad++;
        check(bad == 0, req, bad, 0);
        if (exp_n > 0) check(last_cnt == 1 && last_at == exp_n - 1, "R4 out_last position", last_at, exp_n - 1);
    endtask

    task automatic t_reset;
        do_reset(8'h65);
        #1;
        check(done === 1'b0 && in_ready === 1'b1 && out_valid === 1'b0, "R1 reset state",
              {done, in_ready, out_valid}, 3'b010);
    endtask

    task automatic t_basic_wide;
        do_reset(8'h65);
        put_magic(13, -1);
        put_hdr(8'h61, 3); put_body(3, 5, 0);
        put_hdr(8'h62, 2); put_body(2, 9, 0);
        put_hdr(8'h65, 5); put_body(5, 40, 1);
        put_hdr(8'h63, 4); put_body(4, 77, 0);
        run_stream(0);
        check_payload("R3 R4 wide section extracted");
        check_end("R4 found", ST_FOUND);
    endtask

    task automatic t_short_stalled;
        do_reset(8'h62);
        put_magic(13, -1);
        put_hdr(8'h65, 300); put_body(300, 3, 0);
        put_hdr(8'h61, 255); put_body(255, 11, 0);
        put_hdr(8'h62, 40); put_body(40, 100, 1);
        put_hdr(8'h64, 2); put_body(2, 1, 0);
        run_stream(1);
        check_payload("R6 R4 limit 255 and long wide skip");
        check(bp_bad == 0, "R9 backpressure", bp_bad, 0);
        check_end("R6 found after long sections", ST_FOUND);
    endtask

    task automatic t_magic;
        do_reset(8'h65);
        put_magic(13, 5); put_hdr(8'h65, 3); put_body(3, 0, 0);
        run_stream(0);
        check(got_n == 0, "R2 no output on mismatch", got_n, 0);
        check_end("R2 mismatch", ST_BADMAGIC);
        do_reset(8'h65);
        put_magic(7, -1);
        run_stream(0);
        check_end("R2 truncated signature", ST_BADMAGIC);
    endtask

    task automatic t_bad_type;
        logic [7:0] bads [2] = '{8'h66, 8'h60};
        foreach (bads[i]) begin
            do_reset(8'h65);
            put_magic(13, -1);
            put_hdr(8'h61, 2); put_body(2, 0, 0);
            put(bads[i]); put(8'h00); put(8'h01); put(8'h00);
            run_stream(0);
            check_end("R5 bad type", ST_MALFORMED);
        end
    endtask

    task automatic t_too_long;
        do_reset(8'h65);
        put_magic(13, -1);
        put_hdr(8'h63, 256); put_body(4, 0, 0);
        run_stream(0);
        check_end("R6 short length above limit", ST_MALFORMED);
    endtask

    task automatic t_absent;
        do_reset(8'h64);
        put_magic(13, -1);
        put_hdr(8'h61, 3); put_body(3, 2, 0);
        put_hdr(8'h65, 6); put_body(6, 4, 0);
        put_hdr(8'h62, 1); put_body(1, 6, 0);
        run_stream(0);
        check(got_n == 0, "R3 skipped sections silent", got_n, 0);
        check_end("R7 not found", ST_ABSENT);
        do_reset(8'h64);
        put_magic(13, -1);
        run_stream(0);
        check_end("R7 empty container", ST_ABSENT);
        do_reset(8'h64);
        put_magic(13, -1);
        put_hdr(8'h61, 0);
        run_stream(0);
        check_end("R7 ends on zero length", ST_ABSENT);
    endtask

    task automatic t_truncated;
        do_reset(8'h65);
        put_magic(13, -1);
        put_hdr(8'h65, 10); put_body(4, 50, 1);
        run_stream(0);
        check(got_n == 4, "R8 partial payload", got_n, 4);
        check_end("R8 truncated payload", ST_MALFORMED);
        do_reset(8'h65);
        put_magic(13, -1);
        put(8'h61); put(8'h00);
        run_stream(0);
        check_end("R8 truncated length", ST_MALFORMED);
        do_reset(8'h65);
        put_magic(13, -1);
        put(8'h62);
        run_stream(0);
        check_end("R8 truncated after type", ST_MALFORMED);
    endtask

    task automatic t_zero_len;
        do_reset(8'h63);
        put_magic(13, -1);
        put_hdr(8'h61, 1); put_body(1, 0, 0);
        put_hdr(8'h63, 0);
        put_hdr(8'h64, 3); put_body(3, 0, 0);
        run_stream(0);
        check(got_n == 0, "R11 no output", got_n, 0);
        check_end("R11 zero-length found", ST_FOUND);
    endtask

    initial begin
        t_reset();
        t_basic_wide();
        t_short_stalled();
        t_magic();
        t_bad_type();
        t_too_long();
        t_absent();
        t_truncated();
        t_zero_len();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule